// File: doc/BRIEF.md
# Shift Register Bus Sniffer

This block listens, without driving anything, to the three lines of a serial-in, parallel-out shift register chain: a shift clock line, a serial data line and a latch strobe line. All three are asynchronous to the system clock. The block rebuilds the contents of the chain in a mirror of bytes. It also keeps a second array that models the latched parallel outputs of that chain.

The chain length is a byte count given at run time, so the same block can watch chains of different lengths. Each detected shift-clock edge moves one bit into the mirror. When the strobe is high and at least one bit has been shifted since the last latch, the active bytes of the mirror are copied into the latched array. Another block reads latched bytes one at a time through a combinational read port. A clear input wipes both arrays.

Top module: `srbus_sniffer`

## Requirements
- R1: After reset every latched byte reads 0 at the read port.
- R2: Each line passes through a two-flop synchronizer. A shift happens only on a synchronized low-to-high transition of the shift clock line. A line that first reads high at rising edge N shifts the mirror at edge N+2. Holding the line high for many cycles gives exactly one shift.
- R3: A shift puts the data line value, sampled with the same delay as the shift clock, into bit 0 of byte 0. Bit 7 of byte k moves into bit 0 of byte k+1.
- R4: With a chain length of L, bit 7 of byte L-1 is lost on a shift. Bytes at index L and above are changed by neither a shift nor a latch.
- R5: A chain length of 0 blocks shifting: shift clock edges then change nothing and do not arm a latch.
- R6: Latched bytes change only on a latch. A latch happens at the edge where the synchronized strobe is high and a shift has occurred since the previous latch or clear. It copies bytes 0 to L-1 of the mirror.
- R7: A strobe held high with no new shift causes no further latch. A shift while the strobe stays high causes exactly one more latch, which includes the new bit.
- R8: If a shift and a latch are both due at the same edge, the shift is applied first and the latch follows at the next edge.
- R9: A clear request, sampled at a rising edge, sets every byte of both the mirror and the latched array to 0 and disarms the pending latch. It overrides a shift or latch in that cycle.
- R10: The read data equals the latched byte at the read index in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpLine | input | 1 | Observed shift clock line (asynchronous) |
| dataLine | input | 1 | Observed serial data line (asynchronous) |
| strobeLine | input | 1 | Observed latch strobe line (asynchronous) |
| chainLen | input | LEN_W (9) | Active chain length in bytes, 0 disables shifting |
| clearReq | input | 1 | Synchronous request to zero both arrays |
| rdIdx | input | IDX_W (8) | Byte index for the read port |
| rdData | output | 8 | Latched byte at rdIdx |

## Verification
The mirror cannot be read directly, so a wrong shift or carry only shows up after the next latch. The bench therefore follows every burst of shifts with a strobe and then reads the bytes, and a corrupted bit shows at the read port three edges after the strobe rises. A wrong pending flag shows up differently: the latched bytes either change one cycle too early or too late, or fail to change at all. Comparing against the model on every clock catches this timing, and so does the case where a shift and a latch fall on the same edge.

// File: rtl/srbs_pkg.sv
package srbs_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic clear;   // zero both arrays
    logic shift;   // move one bit into the mirror
    logic copy;    // latch active mirror bytes
    logic bitIn;   // serial bit that enters byte 0
  } srbsCtl_t;

endpackage

// File: rtl/srbs_linesync.sv
module srbs_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cpLine,
  input  logic dataLine,
  input  logic strobeLine,
  output logic cpRise,
  output logic dataBit,
  output logic strobeHigh
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] lineIn;
  logic [2:0] syncQ [SYNC_STAGES];
  logic       cpPrevQ;

  assign lineIn = {strobeLine, dataLine, cpLine};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      cpPrevQ <= 1'b0;
    end else begin
      syncQ[0] <= lineIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      cpPrevQ <= syncQ[LAST][0];
    end
  end

  assign cpRise     = syncQ[LAST][0] & ~cpPrevQ;
  assign dataBit    = syncQ[LAST][1];
  assign strobeHigh = syncQ[LAST][2];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cpRise |=> !cpRise); // R2

endmodule

// File: rtl/srbs_ctrl.sv
module srbs_ctrl import srbs_pkg::*; #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpRise,
  input  logic             dataBit,
  input  logic             strobeHigh,
  input  logic             clearReq,
  input  logic [LEN_W-1:0] chainLen,
  output srbsCtl_t         ctl
);
  logic pendingQ;
  logic shiftDue;

  assign shiftDue = cpRise && (chainLen != '0);

  always_comb begin
    ctl.clear = clearReq;
    ctl.shift = shiftDue && !clearReq;
    // a shift wins the edge; the latch waits one cycle
    ctl.copy  = pendingQ && strobeHigh && !shiftDue && !clearReq;
    ctl.bitIn = dataBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendingQ <= 1'b0;
    else if (ctl.clear) pendingQ <= 1'b0;
    else if (ctl.shift) pendingQ <= 1'b1;
    else if (ctl.copy)  pendingQ <= 1'b0;
  end

  AST_SHIFT_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> pendingQ); // R7
  AST_COPY_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copy |=> !pendingQ); // R7
  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> !pendingQ); // R9
  AST_DEFER_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && strobeHigh) |-> !ctl.copy); // R8

endmodule

// File: rtl/srbs_datapath.sv
module srbs_datapath import srbs_pkg::*; #(
  parameter int MAX_BYTES = 256,
  parameter int LEN_W     = 9,
  parameter int IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  srbsCtl_t         ctl,
  input  logic [LEN_W-1:0] chainLen,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData
);
  logic [7:0]           mirrorQ [MAX_BYTES];
  logic [7:0]           outQ    [MAX_BYTES];
  logic [MAX_BYTES-1:0] carryIn;

  genvar g;
  for (g = 0; g < MAX_BYTES; g++) begin : gByte
    localparam logic [LEN_W-1:0] POS = LEN_W'(g);
    logic       active;
    logic [7:0] mirB;
    logic [7:0] outB;

    assign active = POS < chainLen;

    if (g == 0) begin : gHead
      assign carryIn[g] = ctl.bitIn;
    end else begin : gLink
      assign carryIn[g] = mirrorQ[g-1][7];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mirB <= '0;
        outB <= '0;
      end else if (ctl.clear) begin
        mirB <= '0;
        outB <= '0;
      end else begin
        if (ctl.shift && active) mirB <= {mirB[6:0], carryIn[g]};
        if (ctl.copy && active)  outB <= mirB;
      end
    end

    assign mirrorQ[g] = mirB;
    assign outQ[g]    = outB;
  end

  if (MAX_BYTES == (1 << IDX_W)) begin : gReadFull
    assign rdData = outQ[rdIdx];
  end else begin : gReadGuard
    assign rdData = (rdIdx < IDX_W'(MAX_BYTES)) ? outQ[rdIdx] : 8'h00;
  end

  AST_BIT0_FROM_LINE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift && !ctl.clear |=> mirrorQ[0][0] == $past(ctl.bitIn)); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (mirrorQ[0] == 8'h00) && (outQ[0] == 8'h00)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.copy && !ctl.clear |=> $stable(outQ[0])); // R6
  AST_ZERO_LEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (chainLen == '0) && !ctl.clear |=> $stable(mirrorQ[0])); // R5

  if (MAX_BYTES > 1) begin : gCarryChk
    AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rstN)
      ctl.shift && !ctl.clear && (chainLen >= LEN_W'(2))
        |=> mirrorQ[1][0] == $past(mirrorQ[0][7])); // R3
  end

endmodule

// File: rtl/srbus_sniffer.sv
module srbus_sniffer import srbs_pkg::*; #(
  parameter int MAX_BYTES   = 256,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(MAX_BYTES + 1),
  parameter int IDX_W       = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpLine,
  input  logic             dataLine,
  input  logic             strobeLine,
  input  logic [LEN_W-1:0] chainLen,
  input  logic             clearReq,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData
);
  logic     cpRise;
  logic     dataBit;
  logic     strobeHigh;
  srbsCtl_t ctl;

  srbs_linesync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .cpLine(cpLine), .dataLine(dataLine), .strobeLine(strobeLine),
    .cpRise(cpRise), .dataBit(dataBit), .strobeHigh(strobeHigh)
  );

  srbs_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cpRise(cpRise), .dataBit(dataBit), .strobeHigh(strobeHigh),
    .clearReq(clearReq), .chainLen(chainLen), .ctl(ctl)
  );

  srbs_datapath #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chainLen(chainLen),
    .rdIdx(rdIdx), .rdData(rdData)
  );

endmodule

// File: tb/srbus_sniffer_tb_top.sv
module srbus_sniffer_tb_top;
  localparam int MAXB = 256;

  logic       clk = 0;
  logic       rstN = 0;
  logic       cpLine = 0, dataLine = 0, strobeLine = 0, clearReq = 0;
  logic [8:0] chainLen = 9'd2;
  logic [7:0] rdIdx = 0;
  logic [7:0] rdData;

  always #4 clk = ~clk;

  srbus_sniffer dut_i (
    .clk(clk), .rstN(rstN), .cpLine(cpLine), .dataLine(dataLine),
    .strobeLine(strobeLine), .chainLen(chainLen), .clearReq(clearReq),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  int    vectors = 0, misses = 0;
  string curTag = "R1";
  int    scanIdx = 0, scanMod = 4;

  // behavioural reference
  int mdlMir [MAXB];
  int mdlOut [MAXB];
  int c1, c2, c3, d1, d2, s1, s2, pend, rise;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAXB; i++) begin mdlMir[i] = 0; mdlOut[i] = 0; end
      c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0; s1 = 0; s2 = 0; pend = 0;
    end else begin
      rise = (c2 == 1 && c3 == 0) ? 1 : 0;
      if (clearReq) begin
        for (int i = 0; i < MAXB; i++) begin mdlMir[i] = 0; mdlOut[i] = 0; end
        pend = 0;
      end else if (rise == 1 && chainLen != 0) begin
        for (int i = int'(chainLen) - 1; i >= 1; i--)
          mdlMir[i] = ((mdlMir[i] << 1) | (mdlMir[i-1] >> 7)) & 255;
        mdlMir[0] = ((mdlMir[0] << 1) | d2) & 255;
        pend = 1;
      end else if (pend == 1 && s2 == 1) begin
        for (int i = 0; i < int'(chainLen); i++) mdlOut[i] = mdlMir[i];
        pend = 0;
      end
      c3 = c2; c2 = c1; c1 = int'(cpLine);
      d2 = d1; d1 = int'(dataLine);
      s2 = s1; s1 = int'(strobeLine);
    end
  end

  task automatic report(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: rdData[%0d]=%02h expected %02h", tag, rdIdx, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) report(curTag, int'(rdData), mdlOut[rdIdx]);

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk); #2;
      rdIdx = 8'(scanIdx);
      scanIdx = (scanIdx + 1) % scanMod;
    end
  endtask

  task automatic checkByte(int idx, int exp, string tag);
    rdIdx = 8'(idx);
    #1;
    report(tag, int'(rdData), exp);
  endtask

  task automatic pulse(logic b);
    dataLine = b; cpLine = 1; tick(3);
    cpLine = 0; tick(3);
  endtask

  task automatic latch();
    strobeLine = 1; tick(3);
    strobeLine = 0; tick(3);
  endtask

  task automatic sendBits(int val, int n);
    for (int i = n - 1; i >= 0; i--) pulse(logic'((val >> i) & 1));
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    misses++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    tick(3);
    rstN = 1;
    tick(2);
    curTag = "R1";
    checkByte(0, 8'h00, "R1");
    checkByte(1, 8'h00, "R1");

    curTag = "R3";
    sendBits(16'h3CA5, 16);
    checkByte(0, 8'h00, "R6 before latch");
    latch();
    checkByte(0, 8'hA5, "R3");
    checkByte(1, 8'h3C, "R3");

    curTag = "R4";
    sendBits(8'hFF, 8);
    latch();
    checkByte(0, 8'hFF, "R4");
    checkByte(1, 8'hA5, "R4");
    checkByte(2, 8'h00, "R4 beyond length");

    curTag = "R5";
    chainLen = 9'd0;
    pulse(1); pulse(0); pulse(1);
    latch();
    checkByte(0, 8'hFF, "R5");
    chainLen = 9'd2;
    pulse(0);
    latch();
    checkByte(0, 8'hFE, "R5");
    checkByte(1, 8'h4B, "R5");

    curTag = "R7";
    strobeLine = 1; tick(5);
    pulse(1);
    checkByte(0, 8'hFD, "R7");
    checkByte(1, 8'h97, "R7");
    tick(4);
    strobeLine = 0; tick(3);

    curTag = "R8";
    pulse(0);
    checkByte(0, 8'hFD, "R8 no strobe yet");
    dataLine = 1; cpLine = 1; strobeLine = 1;
    tick(6);
    cpLine = 0; strobeLine = 0;
    tick(3);
    checkByte(0, 8'hF5, "R8");
    checkByte(1, 8'h5F, "R8");

    curTag = "R9";
    clearReq = 1; tick(1); clearReq = 0; tick(1);
    checkByte(0, 8'h00, "R9");
    checkByte(1, 8'h00, "R9");
    latch();
    pulse(1);
    latch();
    checkByte(0, 8'h01, "R9 mirror zeroed");
    checkByte(1, 8'h00, "R9 mirror zeroed");

    curTag = "R2";
    clearReq = 1; tick(1); clearReq = 0;
    chainLen = 9'd1;
    dataLine = 1; cpLine = 1; tick(12);
    cpLine = 0; tick(3);
    latch();
    checkByte(0, 8'h01, "R2 held high");
    pulse(1);
    latch();
    checkByte(0, 8'h03, "R2");
    checkByte(1, 8'h00, "R4 beyond length");

    curTag = "R10";
    checkByte(255, 8'h00, "R10");
    checkByte(0, 8'h03, "R10");
    scanMod = 2;
    tick(4);
    finish();
  end

endmodule